// File: doc/BRIEF.md
# Calibration Bit-Store and Working-Register Loader

This block holds a 128-bit calibration store, kept in flops and cleared at reset. The store is programmed one bit at a time. An erase-all command clears every bit. A set-bit command can only turn one addressed bit from 0 to 1. A read-bit command returns the level of one addressed bit. Erase and set are accepted only while write-enable and chip-select are both high. Each accepted program operation holds a busy flag for a fixed number of clock cycles.

The store is split into 16-bit words. The first five words feed five working registers: one configuration word and four 12-bit trim coefficients (offset, offset drift, span and span drift). A word only reaches its working register when its upper nibble carries the tag expected for its position. Otherwise a per-word error flag is raised and the working register keeps its value.

Loads happen in three cases:
- once right after reset;
- on a chip-select rising edge, unless the update-inhibit input is high;
- periodically from a free-running divider, while write-enable is high and no serial session is active.

A command front end can also stage a value for any working register and copy it in with a separate load strobe.

Top module: `calstore_loader`

## Requirements
- R1: While reset is asserted, every working register, every configuration field and every tag error flag read zero. On the first clock edge after reset release, a load from the store is performed.
- R2: Word k (k = 0..4) occupies store bits 16k..16k+15. Its data is bits 16k..16k+11, with bit 16k+11 as the coefficient MSB. Its tag is bits 16k+12..16k+15, and the expected tag value is 8+k (binary 1000, 1001, 1010, 1011, 1100 read from bit 15 down to bit 12). On a load, a word with a matching tag is copied into its working register: 0 = configuration, 1 = offset, 2 = offset drift, 3 = span, 4 = span drift.
- R3: Configuration word bit fields:
  - bit 0: offset-drift sign
  - bit 1: offset sign
  - bits 2..4: gain select, with bit 2 as the MSB
  - bits 5..6: reserved
  - bit 7: resistor select
  - bit 8: input-offset sign
  - bits 9..11: input-offset magnitude, with bit 9 as the MSB
- R4: An erase clears all 128 bits on the accepting edge. It is accepted only when wr_en and sel are high and busy is low; otherwise the store is unchanged.
- R5: A set command writes 1 to the bit at cmd_addr and leaves all other bits unchanged. It follows the same acceptance rule as R4.
- R6: A read pulse places the bit at cmd_addr on rd_bit one clock later. rd_bit holds that value until the next read.
- R7: After an accepted erase or set, busy is high for exactly BUSY_CYCLES cycles. Erase or set requests made while busy is high are ignored.
- R8: A rising edge on sel with upd_inhibit low loads the working registers on that edge. With upd_inhibit high, the rising edge loads nothing.
- R9: While wr_en is high and session_active is low, a load occurs every REFRESH_DIV cycles. While session_active is high (or wr_en is low), no periodic load occurs.
- R10: On a load, a word whose tag mismatches leaves its working register unchanged and sets tag_err[k]. A load with a matching tag clears tag_err[k].
- R11: stage_we writes stage_data into the staging register selected by stage_sel (0..4). stage_load copies that staged value into the selected working register. A store load in the same cycle takes priority. Selector values 5..7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Chip-select level |
| wr_en | input | 1 | Write-enable level |
| session_active | input | 1 | Serial session running; suspends refresh |
| upd_inhibit | input | 1 | Blocks loads on sel rising edges |
| cmd_erase | input | 1 | Erase-all request |
| cmd_set | input | 1 | Set-bit request |
| cmd_read | input | 1 | Read-bit request |
| cmd_addr | input | 7 | Bit address |
| rd_bit | output | 1 | Read data |
| busy | output | 1 | Program operation in progress |
| stage_we | input | 1 | Staging write strobe |
| stage_sel | input | 3 | Working-register selector |
| stage_data | input | 12 | Staging value |
| stage_load | input | 1 | Copy staged value into working register |
| cfg_otc_sign | output | 1 | Offset-drift sign |
| cfg_off_sign | output | 1 | Offset sign |
| cfg_gain | output | 3 | Gain select |
| cfg_rsel | output | 1 | Resistor select |
| cfg_iro_sign | output | 1 | Input-offset sign |
| cfg_iro_mag | output | 3 | Input-offset magnitude |
| coef_off | output | 12 | Offset coefficient |
| coef_otc | output | 12 | Offset-drift coefficient |
| coef_fso | output | 12 | Span coefficient |
| coef_ftc | output | 12 | Span-drift coefficient |
| tag_err | output | 5 | Per-word tag mismatch flags |

## Verification
A corrupted store bit appears on rd_bit one cycle after a read of that address. It reaches the coefficient outputs one cycle after the next load trigger.

A wrong busy counter shows up in two ways: as a busy pulse of the wrong length, or as a second request that changes the store when it should have been dropped.

A faulty tag comparison or load priority shows at the coefficient and tag_err ports on the cycle after a chip-select edge or refresh tick. A suspended refresh that still fires changes coefficients that should hold across hundreds of cycles.

// File: rtl/calstore_pkg.sv
package calstore_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned TAG_W  = 4;
  localparam int unsigned NREG   = 5;
  localparam int unsigned SEL_W  = 3;

  typedef struct packed {
    logic       otc_sign;
    logic       off_sign;
    logic [2:0] gain;
    logic       rsel;
    logic       iro_sign;
    logic [2:0] iro_mag;
  } cfg_t;

  // Tag nibble each word position must carry
  function automatic logic [TAG_W-1:0] word_tag(input int unsigned k);
    return TAG_W'(8 + k);
  endfunction

  // Split the configuration word into named fields (MSB at lowest bit index)
  function automatic cfg_t decode_cfg(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.otc_sign = w[0];
    c.off_sign = w[1];
    c.gain     = {w[2], w[3], w[4]};
    c.rsel     = w[7];
    c.iro_sign = w[8];
    c.iro_mag  = {w[9], w[10], w[11]};
    return c;
  endfunction
endpackage

// File: rtl/cal_bitstore.sv
module cal_bitstore #(
  parameter int unsigned NBITS       = 128,
  parameter int unsigned BUSY_CYCLES = 16,
  localparam int unsigned AW = $clog2(NBITS),
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow,
  input  logic             erase_req,
  input  logic             set_req,
  input  logic             read_req,
  input  logic [AW-1:0]    addr,
  output logic [NBITS-1:0] bits,
  output logic             rd_bit,
  output logic             busy,
  output logic             prog_accept
);
  logic [CW-1:0] busy_cnt;

  assign busy        = (busy_cnt != '0);
  assign prog_accept = allow && !busy && (erase_req || set_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= '0;
    end else if (prog_accept) begin
      if (erase_req) bits <= '0;
      else           bits[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (prog_accept)      busy_cnt <= CW'(BUSY_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_bit <= 1'b0;
    else if (read_req) rd_bit <= bits[addr];
  end
endmodule

// File: rtl/cal_reload_ctl.sv
module cal_reload_ctl #(
  parameter int unsigned REFRESH_DIV = 256,
  localparam int unsigned DW = $clog2(REFRESH_DIV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic upd_inhibit,
  input  logic wr_en,
  input  logic session_active,
  output logic load_req,
  output logic cs_load,
  output logic refresh_tick
);
  logic          sel_q;
  logic          boot_pend;
  logic [DW-1:0] div_cnt;
  logic          refresh_en;

  assign refresh_en   = wr_en && !session_active;
  assign refresh_tick = refresh_en && (div_cnt == DW'(REFRESH_DIV - 1));
  assign cs_load      = sel && !sel_q && !upd_inhibit;
  assign load_req     = boot_pend || cs_load || refresh_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      boot_pend <= 1'b1;
    end else begin
      sel_q     <= sel;
      boot_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_cnt <= '0;
    else if (!refresh_en)  div_cnt <= '0;
    else if (refresh_tick) div_cnt <= '0;
    else                   div_cnt <= div_cnt + 1'b1;
  end
endmodule

// File: rtl/cal_word_loader.sv
module cal_word_loader
  import calstore_pkg::*;
#(
  parameter int unsigned NW = NREG,
  localparam int unsigned SPAN = NW * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SPAN-1:0]      store_words,
  input  logic                 load_req,
  input  logic                 stage_we,
  input  logic [SEL_W-1:0]     stage_sel,
  input  logic [DATA_W-1:0]    stage_data,
  input  logic                 stage_load,
  output logic [NW*DATA_W-1:0] work_flat,
  output logic [NW-1:0]        tag_err
);
  for (genvar k = 0; k < NW; k++) begin : g_word
    logic [DATA_W-1:0] staged;
    logic [DATA_W-1:0] stored_data;
    logic [TAG_W-1:0]  stored_tag;
    logic              tag_ok;
    logic              hit;

    assign stored_data = store_words[k*WORD_W +: DATA_W];
    assign stored_tag  = store_words[k*WORD_W + DATA_W +: TAG_W];
    assign tag_ok      = (stored_tag == word_tag(k));
    assign hit         = (stage_sel == SEL_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              staged <= '0;
      else if (stage_we && hit) staged <= stage_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        work_flat[k*DATA_W +: DATA_W] <= '0;
        tag_err[k]                    <= 1'b0;
      end else if (load_req) begin
        if (tag_ok) work_flat[k*DATA_W +: DATA_W] <= stored_data;
        tag_err[k] <= !tag_ok;
      end else if (stage_load && hit) begin
        work_flat[k*DATA_W +: DATA_W] <= staged;
      end
    end
  end
endmodule

// File: rtl/calstore_loader.sv
module calstore_loader
  import calstore_pkg::*;
#(
  parameter int unsigned NBITS       = 128,
  parameter int unsigned BUSY_CYCLES = 5_000_000,
  parameter int unsigned REFRESH_DIV = 250_000,
  localparam int unsigned AW = $clog2(NBITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              session_active,
  input  logic              upd_inhibit,
  input  logic              cmd_erase,
  input  logic              cmd_set,
  input  logic              cmd_read,
  input  logic [AW-1:0]     cmd_addr,
  output logic              rd_bit,
  output logic              busy,
  input  logic              stage_we,
  input  logic [SEL_W-1:0]  stage_sel,
  input  logic [DATA_W-1:0] stage_data,
  input  logic              stage_load,
  output logic              cfg_otc_sign,
  output logic              cfg_off_sign,
  output logic [2:0]        cfg_gain,
  output logic              cfg_rsel,
  output logic              cfg_iro_sign,
  output logic [2:0]        cfg_iro_mag,
  output logic [DATA_W-1:0] coef_off,
  output logic [DATA_W-1:0] coef_otc,
  output logic [DATA_W-1:0] coef_fso,
  output logic [DATA_W-1:0] coef_ftc,
  output logic [NREG-1:0]   tag_err
);
  logic [NBITS-1:0]       store_bits;
  logic                   prog_accept;
  logic                   load_req;
  logic                   cs_load;
  logic                   refresh_tick;
  logic [NREG*DATA_W-1:0] work_flat;
  cfg_t                   cfg;

  cal_bitstore #(.NBITS(NBITS), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .allow(wr_en && sel),
    .erase_req(cmd_erase), .set_req(cmd_set), .read_req(cmd_read),
    .addr(cmd_addr), .bits(store_bits), .rd_bit(rd_bit),
    .busy(busy), .prog_accept(prog_accept)
  );

  cal_reload_ctl #(.REFRESH_DIV(REFRESH_DIV)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .upd_inhibit(upd_inhibit),
    .wr_en(wr_en), .session_active(session_active),
    .load_req(load_req), .cs_load(cs_load), .refresh_tick(refresh_tick)
  );

  cal_word_loader #(.NW(NREG)) u_load (
    .clk(clk), .rst_n(rst_n),
    .store_words(store_bits[NREG*WORD_W-1:0]),
    .load_req(load_req), .stage_we(stage_we), .stage_sel(stage_sel),
    .stage_data(stage_data), .stage_load(stage_load),
    .work_flat(work_flat), .tag_err(tag_err)
  );

  assign cfg          = decode_cfg(work_flat[0*DATA_W +: DATA_W]);
  assign cfg_otc_sign = cfg.otc_sign;
  assign cfg_off_sign = cfg.off_sign;
  assign cfg_gain     = cfg.gain;
  assign cfg_rsel     = cfg.rsel;
  assign cfg_iro_sign = cfg.iro_sign;
  assign cfg_iro_mag  = cfg.iro_mag;
  assign coef_off     = work_flat[1*DATA_W +: DATA_W];
  assign coef_otc     = work_flat[2*DATA_W +: DATA_W];
  assign coef_fso     = work_flat[3*DATA_W +: DATA_W];
  assign coef_ftc     = work_flat[4*DATA_W +: DATA_W];
endmodule

// File: rtl/calstore_loader_chk.sv
module calstore_loader_chk #(
  parameter int unsigned NBITS       = 128,
  parameter int unsigned BUSY_CYCLES = 16,
  localparam int unsigned AW = $clog2(NBITS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             cmd_erase,
  input logic [AW-1:0]    cmd_addr,
  input logic             busy,
  input logic             prog_accept,
  input logic [NBITS-1:0] store_bits,
  input logic [4:0]       tag_err,
  input logic [11:0]      coef_off
);
  logic [AW-1:0] last_addr;
  int unsigned   busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      busy_run  <= 0;
    end else begin
      last_addr <= cmd_addr;
      busy_run  <= busy ? busy_run + 1 : 0;
    end
  end

  a_r4_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_accept && cmd_erase |=> (store_bits == '0));

  a_r5_set_marks: assert property (@(posedge clk) disable iff (!rst_n)
    prog_accept && !cmd_erase |=> store_bits[last_addr]);

  a_r4_no_change_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(store_bits));

  a_r7_busy_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    prog_accept |=> busy);

  a_r7_ignore_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(store_bits));

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BUSY_CYCLES);

  a_r10_bad_tag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tag_err[1]) |-> $stable(coef_off));
endmodule

bind calstore_loader calstore_loader_chk #(.NBITS(NBITS), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_erase(cmd_erase),
  .cmd_addr(cmd_addr), .busy(busy), .prog_accept(prog_accept),
  .store_bits(store_bits), .tag_err(tag_err), .coef_off(coef_off)
);

// File: tb/calstore_loader_tb_top.sv
module calstore_loader_tb_top;
  localparam int unsigned BUSY = 4;
  localparam int unsigned DIV  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b1, wr_en = 1'b0, session_active = 1'b1, upd_inhibit = 1'b1;
  logic cmd_erase = 1'b0, cmd_set = 1'b0, cmd_read = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic rd_bit, busy;
  logic stage_we = 1'b0, stage_load = 1'b0;
  logic [2:0] stage_sel = '0;
  logic [11:0] stage_data = '0;
  logic cfg_otc_sign, cfg_off_sign, cfg_rsel, cfg_iro_sign;
  logic [2:0] cfg_gain, cfg_iro_mag;
  logic [11:0] coef_off, coef_otc, coef_fso, coef_ftc;
  logic [4:0] tag_err;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [127:0] model = '0;
  logic [11:0] exp_work [5];
  logic [4:0]  exp_err = '0;

  always #5 clk = ~clk;

  calstore_loader #(.BUSY_CYCLES(BUSY), .REFRESH_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .session_active(session_active), .upd_inhibit(upd_inhibit),
    .cmd_erase(cmd_erase), .cmd_set(cmd_set), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .rd_bit(rd_bit), .busy(busy),
    .stage_we(stage_we), .stage_sel(stage_sel), .stage_data(stage_data),
    .stage_load(stage_load), .cfg_otc_sign(cfg_otc_sign),
    .cfg_off_sign(cfg_off_sign), .cfg_gain(cfg_gain), .cfg_rsel(cfg_rsel),
    .cfg_iro_sign(cfg_iro_sign), .cfg_iro_mag(cfg_iro_mag),
    .coef_off(coef_off), .coef_otc(coef_otc), .coef_fso(coef_fso),
    .coef_ftc(coef_ftc), .tag_err(tag_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Expected reload per R2/R10: tag 8+k in the top nibble of word k
  task automatic model_load();
    for (int k = 0; k < 5; k++) begin
      if (model[16*k+12 +: 4] == 4'(8 + k)) begin
        exp_work[k] = model[16*k +: 12];
        exp_err[k]  = 1'b0;
      end else begin
        exp_err[k]  = 1'b1;
      end
    end
  endtask

  task automatic check_all(input string req);
    logic [11:0] w;
    w = exp_work[0];
    chk(req, "otc_sign", 32'(cfg_otc_sign), 32'(w[0]));
    chk(req, "off_sign", 32'(cfg_off_sign), 32'(w[1]));
    chk(req, "gain", 32'(cfg_gain), 32'(w[2]) * 4 + 32'(w[3]) * 2 + 32'(w[4]));
    chk(req, "rsel", 32'(cfg_rsel), 32'(w[7]));
    chk(req, "iro_sign", 32'(cfg_iro_sign), 32'(w[8]));
    chk(req, "iro_mag", 32'(cfg_iro_mag), 32'(w[9]) * 4 + 32'(w[10]) * 2 + 32'(w[11]));
    chk(req, "coef_off", 32'(coef_off), 32'(exp_work[1]));
    chk(req, "coef_otc", 32'(coef_otc), 32'(exp_work[2]));
    chk(req, "coef_fso", 32'(coef_fso), 32'(exp_work[3]));
    chk(req, "coef_ftc", 32'(coef_ftc), 32'(exp_work[4]));
    chk(req, "tag_err", 32'(tag_err), 32'(exp_err));
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_bit(input int a);
    @(negedge clk); cmd_set = 1'b1; cmd_addr = 7'(a);
    @(negedge clk); cmd_set = 1'b0;
    model[a] = 1'b1;
    wait_idle();
  endtask

  task automatic read_bit(input int a, input string req);
    @(negedge clk); cmd_read = 1'b1; cmd_addr = 7'(a);
    @(negedge clk); cmd_read = 1'b0;
    chk(req, $sformatf("rd_bit[%0d]", a), 32'(rd_bit), 32'(model[a]));
  endtask

  task automatic write_word(input int k, input logic [11:0] d, input logic [3:0] tag);
    logic [15:0] full;
    full = {tag, d};
    for (int b = 0; b < 16; b++) if (full[b]) set_bit(16*k + b);
  endtask

  task automatic cs_pulse(input logic inhibit);
    @(negedge clk); sel = 1'b0; upd_inhibit = inhibit;
    @(negedge clk); sel = 1'b1;
    @(negedge clk); upd_inhibit = 1'b1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 5; k++) exp_work[k] = '0;
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    model_load();
    chk("R1", "boot tag_err", 32'(tag_err), 32'h1f);
    check_all("R10");
  endtask

  task automatic t_program();
    @(negedge clk); wr_en = 1'b1; sel = 1'b1; session_active = 1'b1;
    write_word(0, 12'hA5B, 4'h8);
    write_word(1, 12'h123, 4'h9);
    write_word(2, 12'hFED, 4'hA);
    write_word(3, 12'h800, 4'hB);
    write_word(4, 12'h555, 4'hD);
    read_bit(0, "R6");
    read_bit(2, "R5");
    read_bit(15, "R6");
    read_bit(27, "R2");
    read_bit(64, "R6");
  endtask

  task automatic t_cs_events();
    cs_pulse(1'b1);
    check_all("R8");
    cs_pulse(1'b0);
    model_load();
    check_all("R2");
    chk("R3", "gain", 32'(cfg_gain), 32'd3);
    chk("R3", "iro_mag", 32'(cfg_iro_mag), 32'd5);
    chk("R10", "word4 flag", 32'(tag_err), 32'h10);
  endtask

  task automatic t_busy();
    int hi = 0;
    @(negedge clk); cmd_set = 1'b1; cmd_addr = 7'h60;
    @(negedge clk); cmd_addr = 7'h61;
    model[96] = 1'b1;
    if (busy) hi++;
    @(negedge clk); cmd_set = 1'b0;
    while (busy) begin hi++; @(negedge clk); end
    chk("R7", "busy length", 32'(hi), 32'(BUSY));
    read_bit(97, "R7");
    read_bit(96, "R5");
  endtask

  task automatic t_erase_gate();
    @(negedge clk); wr_en = 1'b0; cmd_erase = 1'b1;
    @(negedge clk); cmd_erase = 1'b0;
    read_bit(0, "R4");
    @(negedge clk); wr_en = 1'b1; sel = 1'b0; cmd_erase = 1'b1;
    @(negedge clk); cmd_erase = 1'b0;
    @(negedge clk); sel = 1'b1;
    read_bit(0, "R4");
  endtask

  task automatic t_stage();
    @(negedge clk); stage_we = 1'b1; stage_sel = 3'd4; stage_data = 12'h3C3;
    @(negedge clk); stage_we = 1'b0; stage_load = 1'b1;
    @(negedge clk); stage_load = 1'b0;
    exp_work[4] = 12'h3C3;
    check_all("R11");
    @(negedge clk); stage_we = 1'b1; stage_sel = 3'd6; stage_data = 12'hFFF;
    @(negedge clk); stage_we = 1'b0; stage_load = 1'b1;
    @(negedge clk); stage_load = 1'b0;
    check_all("R11");
    @(negedge clk); sel = 1'b0; stage_we = 1'b1; stage_sel = 3'd1; stage_data = 12'h0F0;
    @(negedge clk); stage_we = 1'b0; sel = 1'b1; upd_inhibit = 1'b0; stage_load = 1'b1;
    @(negedge clk); stage_load = 1'b0; upd_inhibit = 1'b1;
    model_load();
    check_all("R11");
  endtask

  task automatic t_refresh();
    @(negedge clk); cmd_erase = 1'b1;
    @(negedge clk); cmd_erase = 1'b0;
    model = '0;
    wait_idle();
    read_bit(0, "R4");
    read_bit(27, "R4");
    write_word(1, 12'h777, 4'h9);
    repeat (3 * DIV) @(negedge clk);
    check_all("R9");
    session_active = 1'b0;
    repeat (DIV + 3) @(negedge clk);
    model_load();
    check_all("R9");
    chk("R9", "coef_off refreshed", 32'(coef_off), 32'h777);
    session_active = 1'b1;
  endtask

  initial begin
    t_reset();
    t_program();
    t_cs_events();
    t_busy();
    t_erase_gate();
    t_stage();
    t_refresh();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule